// File: doc/BRIEF.md
# Port-Space Configuration Router

This block sits on the path that handles accesses to the processor's internal I/O port space. Each request carries a port number, a byte count and a direction. The block classifies the request and returns a routed physical address together with a target class. A port that only reaches the configuration mechanism is turned into an address in configuration space. Every other port becomes an address in a flat I/O window.

One 32-bit configuration-address register is held inside the block. A full 4-byte access to the register's port reads it or writes it. The register's top bit gates configuration data accesses. Bits 30:2 of the register, together with the two low bits of the data port, form the configuration-space address. The caller issues the bus transaction itself and does its own permission checks. The block only gives the routing decision, one cycle after the request.

Top module: `ioport_router`

## Requirements
- R1: A request whose port input has any bit above bit 15 set returns `out_error` = 1, target 3 (unmapped), address 0 and read data 0. It leaves the configuration-address register unchanged.
- R2: A request to port 0x0CF8 with `req_size` = 4 returns target 0 (register) and address 0. When it is a read, `out_rdata` carries the register's value from before the request.
- R3: A 4-byte write to port 0x0CF8 loads `req_wdata` into the register, and the new value is visible to the next request. Writes to 0x0CF8 of any other size leave the register unchanged.
- R4: Ports 0x0CFC to 0x0CFF are configuration data ports. With register bit 31 set, they return target 1 and address `CFG_PREFIX | reg[30:2]<<2 | port[1:0]`.
- R5: With register bit 31 clear, a configuration data port returns target 3, address 0 and read data 0xFFFFFFFF. A write returns read data 0.
- R6: Every other port in range returns target 2 and address `IO_PREFIX | port[15:0]`. This includes 0x0CF8 with a size other than 4, and 0x0CF9 to 0x0CFB.
- R7: Synchronous reset clears the register, so configuration data accesses are disabled afterwards, and drives `out_done` low.
- R8: `out_done` pulses exactly once, in the cycle after each cycle in which `req_valid` is high, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_port | input | 32 | Port number; only the low 16 bits may be nonzero |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data for the configuration-address register |
| out_done | output | 1 | Result valid, one cycle after the request |
| out_target | output | 2 | 0 register, 1 config space, 2 I/O window, 3 unmapped |
| out_addr | output | 40 | Routed physical address |
| out_rdata | output | 32 | Register value, all ones for disabled config reads, else 0 |
| out_error | output | 1 | Port number out of 16-bit range |

## Verification
Every routing result, meaning target, address, read data and error flag, appears one clock edge after the edge that captured the request. The bench drives each request on a falling edge and samples the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. A register write shows up in the result of the request that follows it, one cycle later again, and the vector table orders writes and reads so that each read observes the state left by the one before. The back-to-back case checks the first result in the same falling edge that launches the second request.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  typedef enum logic [1:0] {
    TGT_CFGREG  = 2'd0,
    TGT_CFGDATA = 2'd1,
    TGT_IO      = 2'd2,
    TGT_NONE    = 2'd3
  } target_t;

  typedef struct packed {
    logic range_err;
    logic hit_cfgreg;
    logic hit_cfgdata;
  } port_class_t;

endpackage

// File: rtl/ioport_classify.sv
module ioport_classify
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_IN_W = 32,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned REG_BYTES = 4,
  parameter logic [PORT_W-1:0] CFGREG_PORT  = 'h0CF8,
  parameter logic [PORT_W-1:0] CFGDATA_BASE = 'h0CFC
) (
  input  logic [PORT_IN_W-1:0] port,
  input  logic [SIZE_W-1:0]    size,
  output port_class_t          cls
);

  localparam int unsigned LANE_W = 2;

  logic              over;
  logic [PORT_W-1:0] low;

  assign low = port[PORT_W-1:0];

  generate
    if (PORT_IN_W > PORT_W) begin : g_range
      assign over = |port[PORT_IN_W-1:PORT_W];
    end else begin : g_norange
      assign over = 1'b0;
    end
  endgenerate

  always_comb begin
    cls.range_err   = over;
    cls.hit_cfgreg  = !over && (low == CFGREG_PORT) &&
                      (size == SIZE_W'(REG_BYTES));
    cls.hit_cfgdata = !over &&
                      (low[PORT_W-1:LANE_W] == CFGDATA_BASE[PORT_W-1:LANE_W]);
  end

endmodule

// File: rtl/ioport_cfgreg.sv
module ioport_cfgreg #(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (wr_en) begin
      value <= wr_data;
    end
  end

endmodule

// File: rtl/ioport_addr_form.sv
module ioport_addr_form
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned PADDR_W = 40,
  parameter logic [PADDR_W-1:0] CFG_PREFIX = 'hA0_0000_0000,
  parameter logic [PADDR_W-1:0] IO_PREFIX  = 'hC0_0000_0000
) (
  input  port_class_t        cls,
  input  logic [PORT_W-1:0]  port_lo,
  input  logic               is_write,
  input  logic [CFG_W-1:0]   cfg,
  output target_t            target,
  output logic [PADDR_W-1:0] addr,
  output logic [CFG_W-1:0]   rdata
);

  localparam int unsigned EN_BIT = CFG_W - 1;
  localparam int unsigned LANE_W = 2;

  logic [PADDR_W-1:0] cfg_offset;
  logic [PADDR_W-1:0] io_offset;

  assign cfg_offset = PADDR_W'({cfg[EN_BIT-1:LANE_W], port_lo[LANE_W-1:0]});
  assign io_offset  = PADDR_W'(port_lo);

  always_comb begin
    target = TGT_NONE;
    addr   = '0;
    rdata  = '0;
    if (cls.range_err) begin
      target = TGT_NONE;
    end else if (cls.hit_cfgreg) begin
      target = TGT_CFGREG;
      rdata  = is_write ? '0 : cfg;
    end else if (cls.hit_cfgdata) begin
      if (cfg[EN_BIT]) begin
        target = TGT_CFGDATA;
        addr   = CFG_PREFIX | cfg_offset;
      end else begin
        target = TGT_NONE;
        rdata  = is_write ? '0 : '1;
      end
    end else begin
      target = TGT_IO;
      addr   = IO_PREFIX | io_offset;
    end
  end

endmodule

// File: rtl/ioport_router.sv
module ioport_router
  import ioport_pkg::*;
#(
  parameter int unsigned PORT_IN_W = 32,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned PADDR_W   = 40,
  parameter logic [PADDR_W-1:0] CFG_PREFIX = 'hA0_0000_0000,
  parameter logic [PADDR_W-1:0] IO_PREFIX  = 'hC0_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [PORT_IN_W-1:0] req_port,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_write,
  input  logic [CFG_W-1:0]     req_wdata,
  output logic                 out_done,
  output logic [1:0]           out_target,
  output logic [PADDR_W-1:0]   out_addr,
  output logic [CFG_W-1:0]     out_rdata,
  output logic                 out_error
);

  localparam int unsigned REG_BYTES = CFG_W / 8;

  port_class_t        cls;
  logic [CFG_W-1:0]   cfg_q;
  logic               cfg_we;
  target_t            nxt_target;
  logic [PADDR_W-1:0] nxt_addr;
  logic [CFG_W-1:0]   nxt_rdata;

  ioport_classify #(
    .PORT_IN_W (PORT_IN_W),
    .PORT_W    (PORT_W),
    .SIZE_W    (SIZE_W),
    .REG_BYTES (REG_BYTES)
  ) u_classify (
    .port (req_port),
    .size (req_size),
    .cls  (cls)
  );

  assign cfg_we = req_valid && req_write && cls.hit_cfgreg;

  ioport_cfgreg #(
    .CFG_W (CFG_W)
  ) u_cfgreg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_data (req_wdata),
    .value   (cfg_q)
  );

  ioport_addr_form #(
    .PORT_W     (PORT_W),
    .CFG_W      (CFG_W),
    .PADDR_W    (PADDR_W),
    .CFG_PREFIX (CFG_PREFIX),
    .IO_PREFIX  (IO_PREFIX)
  ) u_form (
    .cls      (cls),
    .port_lo  (req_port[PORT_W-1:0]),
    .is_write (req_write),
    .cfg      (cfg_q),
    .target   (nxt_target),
    .addr     (nxt_addr),
    .rdata    (nxt_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done   <= 1'b0;
      out_target <= '0;
      out_addr   <= '0;
      out_rdata  <= '0;
      out_error  <= 1'b0;
    end else begin
      out_done <= req_valid;
      if (req_valid) begin
        out_target <= nxt_target;
        out_addr   <= nxt_addr;
        out_rdata  <= nxt_rdata;
        out_error  <= cls.range_err;
      end
    end
  end

endmodule

// File: rtl/ioport_router_checker.sv
module ioport_router_checker #(
  parameter int unsigned PORT_IN_W = 32,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned CFG_W     = 32,
  parameter int unsigned PADDR_W   = 40,
  parameter logic [PADDR_W-1:0] IO_PREFIX = 'hC0_0000_0000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [PORT_IN_W-1:0] req_port,
  input logic [SIZE_W-1:0]    req_size,
  input logic                 req_write,
  input logic                 out_done,
  input logic [1:0]           out_target,
  input logic [PADDR_W-1:0]   out_addr,
  input logic                 out_error,
  input logic [CFG_W-1:0]     cfg_q
);

  logic prev_valid;

  always_ff @(posedge clk) begin
    if (rst) prev_valid <= 1'b0;
    else     prev_valid <= req_valid;
  end

  // R8: one done per request, one cycle later
  a_r8_done_follows_valid: assert property (@(posedge clk) disable iff (rst)
    out_done == prev_valid);

  // R1: out-of-range port is unmapped with no address
  a_r1_error_unmapped: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_error) |-> (out_target == 2'd3 && out_addr == '0));

  // R3: register only changes after a full-width write to its port
  a_r3_reg_write_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> $past(req_valid && req_write &&
      req_port == PORT_IN_W'(32'h0CF8) && req_size == SIZE_W'(4)));

  // R4: configuration routing only with the enable bit set
  a_r4_cfg_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_target == 2'd1) |-> $past(cfg_q[CFG_W-1]));

  // R6: window results carry the window prefix
  a_r6_io_prefix: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_target == 2'd2) |->
      (out_addr[PADDR_W-1:16] == IO_PREFIX[PADDR_W-1:16]));

  // R7: reset clears the register and done
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !out_done));

endmodule

bind ioport_router ioport_router_checker #(
  .PORT_IN_W (PORT_IN_W),
  .SIZE_W    (SIZE_W),
  .CFG_W     (CFG_W),
  .PADDR_W   (PADDR_W),
  .IO_PREFIX (IO_PREFIX)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_port   (req_port),
  .req_size   (req_size),
  .req_write  (req_write),
  .out_done   (out_done),
  .out_target (out_target),
  .out_addr   (out_addr),
  .out_error  (out_error),
  .cfg_q      (cfg_q)
);

// File: tb/tb_ioport_router.sv
module tb_ioport_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_port = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        out_done;
  logic [1:0]  out_target;
  logic [39:0] out_addr;
  logic [31:0] out_rdata;
  logic        out_error;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ioport_router dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_port   (req_port),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .out_done   (out_done),
    .out_target (out_target),
    .out_addr   (out_addr),
    .out_rdata  (out_rdata),
    .out_error  (out_error)
  );

  typedef struct packed {
    logic [31:0] port;
    logic [2:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [1:0]  tgt;
    logic [39:0] addr;
    logic [31:0] rdata;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{32'h0CFC, 3'd4, 1'b0, 32'h0,        2'd3, 40'h0,           32'hFFFFFFFF, 1'b0, 4'd5}, // R5 disabled after reset
    '{32'h0CF8, 3'd4, 1'b0, 32'h0,        2'd0, 40'h0,           32'h0,        1'b0, 4'd2}, // R2 read of reset value
    '{32'h0CF8, 3'd4, 1'b1, 32'h80012344, 2'd0, 40'h0,           32'h0,        1'b0, 4'd3}, // R3 write
    '{32'h0CF8, 3'd4, 1'b0, 32'h0,        2'd0, 40'h0,           32'h80012344, 1'b0, 4'd3}, // R3 readback
    '{32'h0CFC, 3'd4, 1'b0, 32'h0,        2'd1, 40'hA000012344,  32'h0,        1'b0, 4'd4}, // R4 lane 0
    '{32'h0CFE, 3'd2, 1'b0, 32'h0,        2'd1, 40'hA000012346,  32'h0,        1'b0, 4'd4}, // R4 lane 2
    '{32'h0CFF, 3'd1, 1'b1, 32'h55,       2'd1, 40'hA000012347,  32'h0,        1'b0, 4'd4}, // R4 lane 3 write
    '{32'h0CF8, 3'd2, 1'b0, 32'h0,        2'd2, 40'hC000000CF8,  32'h0,        1'b0, 4'd6}, // R6 narrow reg port
    '{32'h0CF8, 3'd1, 1'b1, 32'h0,        2'd2, 40'hC000000CF8,  32'h0,        1'b0, 4'd6}, // R6 narrow write
    '{32'h0CF8, 3'd4, 1'b0, 32'h0,        2'd0, 40'h0,           32'h80012344, 1'b0, 4'd3}, // R3 narrow write ignored
    '{32'h0080, 3'd1, 1'b0, 32'h0,        2'd2, 40'hC000000080,  32'h0,        1'b0, 4'd6}, // R6
    '{32'hFFFF, 3'd2, 1'b1, 32'h0,        2'd2, 40'hC00000FFFF,  32'h0,        1'b0, 4'd6}, // R6 top port
    '{32'h10CF8,3'd4, 1'b1, 32'h0,        2'd3, 40'h0,           32'h0,        1'b1, 4'd1}, // R1 out of range
    '{32'h0CF8, 3'd4, 1'b0, 32'h0,        2'd0, 40'h0,           32'h80012344, 1'b0, 4'd1}, // R1 register untouched
    '{32'h0CF8, 3'd4, 1'b1, 32'h00000010, 2'd0, 40'h0,           32'h0,        1'b0, 4'd3}, // R3 disable
    '{32'h0CFD, 3'd1, 1'b0, 32'h0,        2'd3, 40'h0,           32'hFFFFFFFF, 1'b0, 4'd5}, // R5 read
    '{32'h0CFB, 3'd1, 1'b0, 32'h0,        2'd2, 40'hC000000CFB,  32'h0,        1'b0, 4'd6}, // R6 gap port
    '{32'h0CFC, 3'd4, 1'b1, 32'h0,        2'd3, 40'h0,           32'h0,        1'b0, 4'd5}, // R5 write
    '{32'h0CF8, 3'd4, 1'b1, 32'hFFFFFFFF, 2'd0, 40'h0,           32'h0,        1'b0, 4'd3}, // R3 all ones
    '{32'h0CFF, 3'd4, 1'b0, 32'h0,        2'd1, 40'hA07FFFFFFF,  32'h0,        1'b0, 4'd4}, // R4 full field
    '{32'h80000CFC,3'd2,1'b0, 32'h0,      2'd3, 40'h0,           32'h0,        1'b1, 4'd1}, // R1 top bit
    '{32'h0CF8, 3'd4, 1'b0, 32'h0,        2'd0, 40'h0,           32'hFFFFFFFF, 1'b0, 4'd2}  // R2 readback
  };

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] p, logic [2:0] s, logic w, logic [31:0] d);
    req_valid = 1'b1;
    req_port  = p;
    req_size  = s;
    req_write = w;
    req_wdata = d;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_port  = '0;
    req_size  = '0;
    req_write = 1'b0;
    req_wdata = '0;
  endtask

  task automatic check_result(string rq, logic [1:0] tgt, logic [39:0] addr,
                              logic [31:0] rdata, logic err);
    chk(rq, "done",   64'(out_done),   64'd1);
    chk(rq, "target", 64'(out_target), 64'(tgt));
    chk(rq, "addr",   64'(out_addr),   64'(addr));
    chk(rq, "rdata",  64'(out_rdata),  64'(rdata));
    chk(rq, "error",  64'(out_error),  64'(err));
  endtask

  task automatic apply(string rq, logic [31:0] p, logic [2:0] s, logic w,
                       logic [31:0] d, logic [1:0] tgt, logic [39:0] addr,
                       logic [31:0] rdata, logic err);
    @(negedge clk);
    drive(p, s, w, d);
    @(negedge clk);
    idle();
    check_result(rq, tgt, addr, rdata, err);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state
    chk("R7", "done at reset", 64'(out_done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "no done without request", 64'(out_done), 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].port, VEC[i].size, VEC[i].wr, VEC[i].wdata);
      @(negedge clk);
      idle();
      check_result($sformatf("R%0d row %0d", VEC[i].rq, i),
                   VEC[i].tgt, VEC[i].addr, VEC[i].rdata, VEC[i].err);
    end

    // R8: idle cycle after a request has no done
    @(negedge clk);
    chk("R8", "done while idle", 64'(out_done), 64'd0);

    // R8 and R3: back-to-back write then read, new value seen by the next request
    @(negedge clk);
    drive(32'h0CF8, 3'd4, 1'b1, 32'h8000ABC0);
    @(negedge clk);
    drive(32'h0CFD, 3'd1, 1'b0, 32'h0);
    check_result("R8 first", 2'd0, 40'h0, 32'h0, 1'b0);
    @(negedge clk);
    idle();
    check_result("R3 second", 2'd1, 40'hA00000ABC1, 32'h0, 1'b0);

    // R7: reset mid-run clears the register
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "done in reset", 64'(out_done), 64'd0);
    rst = 1'b0;
    apply("R7 reg cleared", 32'h0CF8, 3'd4, 1'b0, 32'h0, 2'd0, 40'h0, 32'h0, 1'b0);
    apply("R7 config disabled", 32'h0CFE, 3'd2, 1'b0, 32'h0, 2'd3, 40'h0,
          32'hFFFFFFFF, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule